// File: doc/BRIEF.md
# Reset-Selectable Fall-Through Synchronous FIFO

This block is a single-clock FIFO for 36-bit words. Its read timing is chosen once after each reset. While reset is low and on the first rising clock edge after release, the block accepts no traffic. At that edge it samples the active-low mode select pin. LOW picks fall-through timing and HIGH picks standard timing. The choice then holds until the next reset, whatever the pin does.

In standard timing, the consumer raises a read request while the FIFO is not empty. The next word shows on the read data bus after that clock edge. Occupancy is reported by empty and full flags.

In fall-through timing, a word written to an empty FIFO lands on the read data bus by itself at the write edge. Each later word is taken by a read request. An output-ready signal marks valid data on the bus, and an input-ready signal marks room for a write. The output register counts as one storage slot, so fall-through mode holds one word more than the memory depth.

Top module: `modal_sync_fifo`

## Requirements
- R1: While reset is low, all four status outputs and the read data bus are 0. On the first clock edge after release, writes and reads are ignored.
- R2: At the first rising edge after reset release, mode select LOW chooses fall-through mode (input-ready goes to 1) and HIGH chooses standard mode (empty goes to 1).
- R3: After that edge, the chosen mode does not change until the next reset, whatever the mode select input does.
- R4: In fall-through mode, a word written while output-ready is 0 and the memory is empty appears on the read data bus, with output-ready at 1, right after that same write edge. No read request is needed.
- R5: In fall-through mode, a read with output-ready at 1 replaces the bus word with the next stored word at that edge. If nothing is stored, output-ready drops to 0. Without a read, the bus word and output-ready hold.
- R6: In fall-through mode, input-ready is 0 exactly when DEPTH words wait behind the output register, so DEPTH+1 words in total are held.
- R7: In standard mode, empty is 1 when no words are stored and full is 1 when DEPTH words are stored, while input-ready and output-ready stay 0. In fall-through mode, empty and full stay 0.
- R8: In standard mode, a read while empty is 0 puts the oldest stored word on the read data bus after that edge. Otherwise the bus holds its last value.
- R9: A write while full (standard mode) or while input-ready is 0 (fall-through mode) is ignored. A read while empty or while output-ready is 0 is also ignored. Stored contents and order are unchanged.
- R10: Words leave in the order they were accepted, including when a write and a read occur at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel_n | input | 1 | Timing select sampled once after reset: 0 fall-through, 1 standard |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read word |
| in_rdy | output | 1 | Fall-through mode: room for a write |
| out_rdy | output | 1 | Fall-through mode: valid word on rd_data |
| empty | output | 1 | Standard mode: no words stored |
| full | output | 1 | Standard mode: DEPTH words stored |

## Verification
The bench builds the block with DEPTH set to 5 and the default 36-bit data width. A depth of 5 exercises the pointer wrap used for depths that are not a power of two. It also lets a handful of writes reach the full limit in both modes, so the ignored-write and ignored-read cases come up often during random traffic. Both modes run with the select pin toggling freely after the lock edge.

// File: rtl/msf_pkg.sv
package msf_pkg;
   typedef enum logic [0:0] {
      MSF_STD  = 1'b0,
      MSF_FWFT = 1'b1
   } msf_mode_e;
endpackage

// File: rtl/msf_mode_latch.sv
module msf_mode_latch
   import msf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel_n,
   output msf_mode_e mode,
   output logic      locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= MSF_STD;
         locked <= 1'b0;
      end else if (!locked) begin
         mode   <= sel_n ? MSF_STD : MSF_FWFT;
         locked <= 1'b1;
      end
   end

   // R3
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (locked && $stable(mode)));
endmodule

// File: rtl/msf_store.sv
module msf_store #(
   parameter int DATA_W = 36,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic              is_empty,
   output logic              is_full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr, wnext, rnext;
   logic [CW-1:0]     cnt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         always_comb begin
            wnext = wptr + 1'b1;
            rnext = rptr + 1'b1;
         end
      end else begin : g_cmp_wrap
         always_comb begin
            wnext = (wptr == LAST) ? '0 : wptr + 1'b1;
            rnext = (rptr == LAST) ? '0 : rptr + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push) wptr <= wnext;
         if (pop)  rptr <= rnext;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign pop_data = mem[rptr];
   assign is_empty = (cnt == '0);
   assign is_full  = (cnt == CW'(DEPTH));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !is_full);
   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !is_empty);
   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/msf_out_stage.sv
module msf_out_stage
   import msf_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  msf_mode_e         mode,
   input  logic              locked,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              st_empty,
   input  logic              st_full,
   input  logic [DATA_W-1:0] st_rdata,
   output logic              push,
   output logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              in_rdy,
   output logic              out_rdy,
   output logic              empty,
   output logic              full
);
   logic std_on, ft_on, wr_acc, std_rd, take, bypass, ovalid;

   always_comb begin
      std_on = locked && (mode == MSF_STD);
      ft_on  = locked && (mode == MSF_FWFT);
      wr_acc = locked && wr_en && !st_full;
      std_rd = std_on && rd_en && !st_empty;
      take   = ft_on && (!ovalid || rd_en);
      bypass = take && st_empty && wr_acc;
      pop    = std_rd || (take && !st_empty);
      push   = wr_acc && !bypass;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         ovalid  <= 1'b0;
      end else if (std_rd) begin
         rd_data <= st_rdata;
      end else if (take) begin
         if (!st_empty) begin
            rd_data <= st_rdata;
            ovalid  <= 1'b1;
         end else if (bypass) begin
            rd_data <= wr_data;
            ovalid  <= 1'b1;
         end else begin
            ovalid  <= 1'b0;
         end
      end
   end

   assign in_rdy  = ft_on && !st_full;
   assign out_rdy = ft_on && ovalid;
   assign empty   = std_on && st_empty;
   assign full    = std_on && st_full;

   // R5
   ft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_rdy && !rd_en) |=> (out_rdy && $stable(rd_data)));
   // R8
   std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (std_on && !(rd_en && !empty)) |=> $stable(rd_data));
   // R7
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((in_rdy || out_rdy) && (empty || full)));
endmodule

// File: rtl/modal_sync_fifo.sv
module modal_sync_fifo
   import msf_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sel_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              in_rdy,
   output logic              out_rdy,
   output logic              empty,
   output logic              full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("modal_sync_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("modal_sync_fifo: DATA_W must be positive");
      end
   endgenerate

   msf_mode_e         mode;
   logic              locked, push, pop, st_empty, st_full;
   logic [DATA_W-1:0] st_rdata;

   msf_mode_latch u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_n  (mode_sel_n),
      .mode   (mode),
      .locked (locked)
   );

   msf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (wr_data),
      .pop       (pop),
      .pop_data  (st_rdata),
      .is_empty  (st_empty),
      .is_full   (st_full)
   );

   msf_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .locked   (locked),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .st_empty (st_empty),
      .st_full  (st_full),
      .st_rdata (st_rdata),
      .push     (push),
      .pop      (pop),
      .rd_data  (rd_data),
      .in_rdy   (in_rdy),
      .out_rdy  (out_rdy),
      .empty    (empty),
      .full     (full)
   );

   // R1
   idle_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !(push || pop));
endmodule

// File: tb/modal_sync_fifo_bench.sv
module modal_sync_fifo_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 36;
   localparam int DEPTH = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_sel_n = 1'b1;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          in_rdy, out_rdy, empty, full;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   bit            m_locked;
   bit            m_ft;
   bit            m_ov;
   logic [DW-1:0] m_out;
   logic [DW-1:0] m_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   modal_sync_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_modal_sync_fifo (
      .clk(clk), .rst_n(rst_n), .mode_sel_n(mode_sel_n),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .in_rdy(in_rdy), .out_rdy(out_rdy),
      .empty(empty), .full(full)
   );

   function automatic logic [3:0] exp_flags();
      if (!m_locked) return 4'b0000;
      if (m_ft) return {(m_q.size() < DEPTH), m_ov, 1'b0, 1'b0};
      return {1'b0, 1'b0, (m_q.size() == 0), (m_q.size() == DEPTH)};
   endfunction

   function automatic void model_step(bit w, logic [DW-1:0] d, bit r, bit sel);
      bit wacc;
      if (!m_locked) begin
         m_locked = 1;
         m_ft = !sel;
         return;
      end
      wacc = w && (m_q.size() < DEPTH);
      if (!m_ft) begin
         if (r && m_q.size() > 0) m_out = m_q.pop_front();
         if (wacc) m_q.push_back(d);
      end else if (!m_ov || r) begin
         if (m_q.size() > 0) begin
            m_out = m_q.pop_front();
            m_ov = 1;
            if (wacc) m_q.push_back(d);
         end else if (wacc) begin
            m_out = d;
            m_ov = 1;
         end else begin
            m_ov = 0;
         end
      end else if (wacc) begin
         m_q.push_back(d);
      end
   endfunction

   task automatic compare(string tag);
      logic [3:0] ef, af;
      bit data_ok;
      ef = exp_flags();
      af = {in_rdy, out_rdy, empty, full};
      data_ok = (m_locked && m_ft && !m_ov) ? 1'b1 : (rd_data === m_out);
      n_vec++;
      if (af !== ef || !data_ok) begin
         n_bad++;
         $display("FAIL %s: flags(in,out,empty,full)=%b data=%h expected flags=%b data=%h",
                  tag, af, rd_data, ef, m_out);
      end
   endtask

   task automatic step(bit w, logic [DW-1:0] d, bit r, bit sel, string tag);
      wr_en = w; wr_data = d; rd_en = r; mode_sel_n = sel;
      model_step(w, d, r, sel);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset(bit sel);
      @(negedge clk);
      rst_n = 0; wr_en = 0; rd_en = 0; mode_sel_n = sel;
      m_locked = 0; m_ft = 0; m_ov = 0; m_out = '0; m_q.delete();
      @(negedge clk);
      compare("R1 reset state");
      rst_n = 1;
      // lock edge: write and read must be ignored
      step(1, 36'hBAD_0BAD0, 1, sel, "R1 lock edge ignores traffic");
   endtask

   task automatic random_run(int n, string tag);
      for (int i = 0; i < n; i++) begin
         bit w, r, s;
         w = ($urandom % 3) != 0;
         r = ($urandom % 3) != 0;
         s = $urandom % 2;
         step(w, {$urandom, 4'($urandom)}, r, s, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      // fall-through mode
      do_reset(1'b0);
      step(0, '0, 0, 1, "R2 fall-through selected");
      step(1, 36'h1_0000_0001, 0, 1, "R4 first word falls through");
      step(0, '0, 0, 0, "R5 holds without read");
      for (int i = 2; i <= DEPTH + 1; i++)
         step(1, 36'(i), 0, 1, "R6 filling");
      step(1, 36'hF_FFFF_FFFF, 0, 0, "R9 write ignored when not ready");
      for (int i = 0; i < DEPTH + 1; i++)
         step(0, '0, 1, 1, "R5 explicit reads advance");
      step(0, '0, 1, 0, "R9 read ignored when not ready");
      step(1, 36'h2_2222_2222, 1, 1, "R4 write with read on empty");
      random_run(400, "R10 order under mixed traffic R3");

      // standard mode
      do_reset(1'b1);
      step(0, '0, 0, 0, "R2 standard selected");
      step(0, '0, 1, 0, "R9 read ignored when empty");
      for (int i = 1; i <= DEPTH; i++)
         step(1, 36'(i * 3), 0, 1, "R7 flags while filling");
      step(1, 36'hE_EEEE_EEEE, 0, 0, "R9 write ignored when full");
      step(1, 36'hD_DDDD_DDDD, 1, 1, "R8 read while full");
      for (int i = 0; i < DEPTH; i++)
         step(0, '0, 1, 0, "R8 read next word");
      step(0, '0, 0, 1, "R8 data holds");
      random_run(400, "R10 order under mixed traffic R3");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule